// File: doc/BRIEF.md
# Fast Interrupt Vectoring Arbiter

This block chooses, every clock, which pending interrupt request should be serviced next. Each request line carries a priority level supplied alongside it; level 0 means the line is switched off. Ordinary requests are ranked by level and then by index. The winner's service address is a programmable table base plus twice the request number.

Two request numbers can be singled out as fast interrupts. A pending fast interrupt sits above every ordinary level-2 request, but below level 3. Its output address is a 21-bit value programmed for it directly, with no table arithmetic. When both fast interrupts are pending, fast slot 0 is chosen over fast slot 1.

A 16-bit register port holds the configuration:
- two match registers naming the fast request numbers;
- two low/high pairs carrying the fast target addresses;
- one low/high pair carrying the table base.

The result is registered, so it appears one clock after the pending lines and levels are sampled.

Top module: `fiv_arbiter`

## Requirements
- R1: Register offsets 0 and 1 are the fast-0 and fast-1 match registers. Each keeps a 7-bit request number in bits 6:0. Bits 15:7 read as zero whatever is written. Both reset to zero, so after reset request 0 is fast slot 0.
- R2: Offsets 2/3 hold the fast-0 address and offsets 4/5 the fast-1 address. Offsets 6/7 hold the table base. In each pair, the even offset gives address bits 15:0 and the odd offset gives bits 20:16 in its bits 4:0. The other bits of the odd register read as zero. All of these reset to zero.
- R3: Request i's level sits at irq_lvl[2i+1:2i]. A request at level 0 never wins. win_valid is low when no request at level 1 or above is pending.
- R4: Outputs change one clock after the sampled inputs. Register writes made at that same edge do not affect that result; they first count at the following edge.
- R5: Among ordinary requests, the higher level wins. At equal level, the lower index wins.
- R6: An ordinary winner gives win_fast = 0 and win_addr = table base + 2 × request number, modulo 2^21.
- R7: A pending fast request at a nonzero level beats every ordinary request at level 1 or 2, whatever its index. An ordinary request at level 3 beats it.
- R8: If both fast slots have a pending request, slot 0 wins. If both match registers name the same request, slot 0 is used.
- R9: A fast winner gives win_fast = 1, win_irq = its request number, and win_addr = that slot's programmed 21-bit address.
- R10: During reset, win_valid, win_fast, win_irq and win_addr are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_pend | input | NUM_IRQ | Pending flag per request |
| irq_lvl | input | NUM_IRQ*LVL_W | Priority level per request, 2 bits each by default |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register offset |
| reg_wdata | input | 16 | Register write data |
| reg_rdata | output | 16 | Register read data, combinational on reg_addr |
| win_valid | output | 1 | A winner exists |
| win_fast | output | 1 | The winner is a fast interrupt |
| win_irq | output | 7 | Winning request number |
| win_addr | output | 21 | Service address for the winner |

## Verification
Two things can happen in the same cycle: a write that re-targets a fast match register, and arbitration of the very request being named. The bench holds an ordinary level-2 request pending and rewrites fast slot 0 to point at it in that same cycle. The first registered result must still be the table-based ordinary winner. The fast vector must appear only one clock later. Separately, an ordinary level-2 request and a fast request are made pending together, to judge whether the fast promotion holds regardless of index, and a level-3 request is added to confirm it still overrides.

// File: rtl/fiv_pkg.sv
package fiv_pkg;
  localparam int REG_W  = 16;
  localparam int VEC_W  = 21;
  localparam int IDX_W  = 7;
  localparam int RADR_W = 3;
  localparam int NREG   = 8;
  localparam int HI_W   = VEC_W - REG_W;

  typedef enum logic [RADR_W-1:0] {
    RG_MATCH0 = 3'd0,
    RG_MATCH1 = 3'd1,
    RG_F0_LO  = 3'd2,
    RG_F0_HI  = 3'd3,
    RG_F1_LO  = 3'd4,
    RG_F1_HI  = 3'd5,
    RG_TB_LO  = 3'd6,
    RG_TB_HI  = 3'd7
  } fiv_reg_e;

  function automatic logic [REG_W-1:0] reg_mask(input int k);
    logic [REG_W-1:0] m;
    if (k < 2)           m = REG_W'((1 << IDX_W) - 1);
    else if (k % 2 == 1) m = REG_W'((1 << HI_W) - 1);
    else                 m = '1;
    return m;
  endfunction
endpackage

// File: rtl/fiv_regs.sv
module fiv_regs
  import fiv_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                wr_en,
  input  logic [RADR_W-1:0]   addr,
  input  logic [REG_W-1:0]    wdata,
  output logic [REG_W-1:0]    rdata,
  output logic [IDX_W-1:0]    match0,
  output logic [IDX_W-1:0]    match1,
  output logic [VEC_W-1:0]    fvec0,
  output logic [VEC_W-1:0]    fvec1,
  output logic [VEC_W-1:0]    tbase
);
  logic [REG_W-1:0] q [NREG];
  logic [REG_W-1:0] d [NREG];

  for (genvar k = 0; k < NREG; k++) begin : g_reg
    localparam logic [REG_W-1:0] MASK = reg_mask(k);
    logic ld;
    always_comb begin
      ld   = wr_en && (addr == RADR_W'(k));
      d[k] = ld ? (wdata & MASK) : q[k];
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  q[k] <= '0;
      else if (ld) q[k] <= d[k];
    end
  end

  always_comb begin
    rdata  = q[addr];
    match0 = q[RG_MATCH0][IDX_W-1:0];
    match1 = q[RG_MATCH1][IDX_W-1:0];
    fvec0  = {q[RG_F0_HI][HI_W-1:0], q[RG_F0_LO]};
    fvec1  = {q[RG_F1_HI][HI_W-1:0], q[RG_F1_LO]};
    tbase  = {q[RG_TB_HI][HI_W-1:0], q[RG_TB_LO]};
  end

  AST_MATCH_LOADS: assert property (@(posedge clk) disable iff (!rst_n)
    $past(wr_en && addr == RG_MATCH0) |-> match0 == $past(wdata[IDX_W-1:0])) // R1
    else $error("match0 load");
  AST_READ_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (addr == RG_MATCH0 || addr == RG_MATCH1) |-> rdata[REG_W-1:IDX_W] == '0) // R1
    else $error("match upper bits");
endmodule

// File: rtl/fiv_fastsel.sv
module fiv_fastsel
  import fiv_pkg::*;
#(
  parameter int NUM_IRQ  = 64,
  parameter int NUM_FAST = 2
)(
  input  logic [NUM_IRQ-1:0]            pend,
  input  logic [NUM_IRQ-1:0]            enabled,
  input  logic [NUM_FAST*IDX_W-1:0]     match,
  output logic [NUM_IRQ-1:0]            fast_mask,
  output logic [NUM_FAST-1:0]           hit
);
  logic [NUM_IRQ-1:0] sel [NUM_FAST];

  for (genvar f = 0; f < NUM_FAST; f++) begin : g_slot
    for (genvar i = 0; i < NUM_IRQ; i++) begin : g_cmp
      assign sel[f][i] = (match[f*IDX_W +: IDX_W] == IDX_W'(i));
    end
    assign hit[f] = |(sel[f] & pend & enabled);
  end

  always_comb begin
    fast_mask = '0;
    for (int f = 0; f < NUM_FAST; f++) fast_mask = fast_mask | sel[f];
  end
endmodule

// File: rtl/fiv_prio.sv
module fiv_prio
  import fiv_pkg::*;
#(
  parameter int NUM_IRQ = 64,
  parameter int LVL_W   = 2
)(
  input  logic [NUM_IRQ-1:0]       pend,
  input  logic [NUM_IRQ*LVL_W-1:0] lvl,
  input  logic [NUM_IRQ-1:0]       excl,
  output logic                     any,
  output logic [IDX_W-1:0]         idx,
  output logic [LVL_W-1:0]         best_lvl
);
  always_comb begin
    best_lvl = '0;
    idx      = '0;
    for (int i = 0; i < NUM_IRQ; i++) begin
      if (pend[i] && !excl[i] && (lvl[i*LVL_W +: LVL_W] > best_lvl)) begin
        best_lvl = lvl[i*LVL_W +: LVL_W];
        idx      = IDX_W'(i);
      end
    end
    any = (best_lvl != '0);
  end
endmodule

// File: rtl/fiv_arbiter.sv
module fiv_arbiter
  import fiv_pkg::*;
#(
  parameter int NUM_IRQ  = 64,
  parameter int LVL_W    = 2,
  parameter int FAST_LVL = 2
)(
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic [NUM_IRQ-1:0]         irq_pend,
  input  logic [NUM_IRQ*LVL_W-1:0]   irq_lvl,
  input  logic                       reg_wr,
  input  logic [RADR_W-1:0]          reg_addr,
  input  logic [REG_W-1:0]           reg_wdata,
  output logic [REG_W-1:0]           reg_rdata,
  output logic                       win_valid,
  output logic                       win_fast,
  output logic [IDX_W-1:0]           win_irq,
  output logic [VEC_W-1:0]           win_addr
);
  localparam int NUM_FAST = 2;
  localparam logic [LVL_W-1:0] FAST_TIER = LVL_W'(FAST_LVL);

  logic [IDX_W-1:0]   match0, match1;
  logic [VEC_W-1:0]   fvec0, fvec1, tbase;
  logic [NUM_IRQ-1:0] enabled, fast_mask;
  logic [NUM_FAST-1:0] hit;
  logic               norm_any;
  logic [IDX_W-1:0]   norm_idx;
  logic [LVL_W-1:0]   norm_lvl;
  logic               norm_over;

  logic               valid_d, fast_d;
  logic [IDX_W-1:0]   irq_d;
  logic [VEC_W-1:0]   addr_d;

  fiv_regs u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(reg_wr), .addr(reg_addr),
    .wdata(reg_wdata), .rdata(reg_rdata), .match0(match0), .match1(match1),
    .fvec0(fvec0), .fvec1(fvec1), .tbase(tbase)
  );

  for (genvar i = 0; i < NUM_IRQ; i++) begin : g_en
    assign enabled[i] = |irq_lvl[i*LVL_W +: LVL_W];
  end

  fiv_fastsel #(.NUM_IRQ(NUM_IRQ), .NUM_FAST(NUM_FAST)) u_fast (
    .pend(irq_pend), .enabled(enabled), .match({match1, match0}),
    .fast_mask(fast_mask), .hit(hit)
  );

  fiv_prio #(.NUM_IRQ(NUM_IRQ), .LVL_W(LVL_W)) u_prio (
    .pend(irq_pend), .lvl(irq_lvl), .excl(fast_mask),
    .any(norm_any), .idx(norm_idx), .best_lvl(norm_lvl)
  );

  always_comb begin
    norm_over = norm_any && (norm_lvl > FAST_TIER);
    valid_d   = 1'b0;
    fast_d    = 1'b0;
    irq_d     = '0;
    addr_d    = '0;
    if (!norm_over && hit[0]) begin
      valid_d = 1'b1;
      fast_d  = 1'b1;
      irq_d   = match0;
      addr_d  = fvec0;
    end else if (!norm_over && hit[1]) begin
      valid_d = 1'b1;
      fast_d  = 1'b1;
      irq_d   = match1;
      addr_d  = fvec1;
    end else if (norm_any) begin
      valid_d = 1'b1;
      irq_d   = norm_idx;
      addr_d  = tbase + {{(VEC_W-IDX_W-1){1'b0}}, norm_idx, 1'b0};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      win_valid <= 1'b0;
      win_fast  <= 1'b0;
      win_irq   <= '0;
      win_addr  <= '0;
    end else begin
      win_valid <= valid_d;
      win_fast  <= fast_d;
      win_irq   <= irq_d;
      win_addr  <= addr_d;
    end
  end

  AST_FAST_IMPLIES_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    win_fast |-> win_valid) // R9
    else $error("fast without valid");
  AST_WINNER_WAS_PENDING: assert property (@(posedge clk) disable iff (!rst_n)
    win_valid |-> $past(irq_pend) != '0) // R3
    else $error("winner with nothing pending");
  AST_SLOT0_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(hit[0]) && !$past(norm_over)) |-> (win_fast && win_irq == $past(match0)
      && win_addr == $past(fvec0))) // R8
    else $error("slot 0 not chosen");
  AST_TABLE_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
    (win_valid && !win_fast) |-> win_addr == $past(tbase) + VEC_W'({win_irq, 1'b0})) // R6
    else $error("table address");
  AST_LEVEL3_OVERRIDES: assert property (@(posedge clk) disable iff (!rst_n)
    $past(norm_over) |-> (win_valid && !win_fast)) // R7
    else $error("level 3 lost to fast");
endmodule

// File: tb/fiv_arbiter_test.sv
`timescale 1ns/1ps
module fiv_arbiter_test;
  localparam int N = 64;
  localparam int LW = 2;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [N-1:0]  irq_pend = '0;
  logic [N*LW-1:0] irq_lvl = '0;
  logic          reg_wr = 1'b0;
  logic [2:0]    reg_addr = '0;
  logic [15:0]   reg_wdata = '0;
  logic [15:0]   reg_rdata;
  logic          win_valid, win_fast;
  logic [6:0]    win_irq;
  logic [20:0]   win_addr;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #4 clk = ~clk;

  fiv_arbiter uut (
    .clk(clk), .rst_n(rst_n), .irq_pend(irq_pend), .irq_lvl(irq_lvl),
    .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .win_valid(win_valid), .win_fast(win_fast),
    .win_irq(win_irq), .win_addr(win_addr)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [15:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd_chk(input string req, input logic [2:0] a, input logic [15:0] exp);
    @(negedge clk);
    reg_addr = a;
    #1 chk(req, {16'h0, reg_rdata}, {16'h0, exp});
  endtask

  task automatic put(input int i, input int l);
    irq_pend[i] = 1'b1;
    irq_lvl[i*LW +: LW] = LW'(l);
  endtask

  // apply current pend/lvl at a falling edge; result after next rising edge
  task automatic expect_win(input string req, input logic v, input logic f,
                            input logic [6:0] irq, input logic [20:0] adr);
    @(posedge clk); #1;
    chk({req, " valid"}, {31'h0, win_valid}, {31'h0, v});
    chk({req, " fast"},  {31'h0, win_fast},  {31'h0, f});
    if (v) begin
      chk({req, " irq"},  {25'h0, win_irq},  {25'h0, irq});
      chk({req, " addr"}, {11'h0, win_addr}, {11'h0, adr});
    end
  endtask

  task automatic clear_irqs();
    @(negedge clk);
    irq_pend = '0; irq_lvl = '0;
  endtask

  localparam logic [20:0] TB = 21'h11000;
  localparam logic [20:0] FV0 = 21'h1ABCD;
  localparam logic [20:0] FV1 = 21'h0F00D;

  task automatic t_reset();
    #1;
    chk("R10 valid", {31'h0, win_valid}, 0);
    chk("R10 fast",  {31'h0, win_fast}, 0);
    chk("R10 addr",  {11'h0, win_addr}, 0);
    rst_n = 1'b1;
    rd_chk("R1 match0 reset", 3'd0, 16'h0);
    rd_chk("R2 tbase hi reset", 3'd7, 16'h0);
  endtask

  task automatic t_regs();
    wr(3'd0, 16'hFFFF); rd_chk("R1 match0 mask", 3'd0, 16'h007F);
    wr(3'd3, 16'hFFFF); rd_chk("R2 f0 hi mask", 3'd3, 16'h001F);
    wr(3'd0, 16'd40); wr(3'd1, 16'd41);
    rd_chk("R1 match1", 3'd1, 16'd41);
    wr(3'd2, FV0[15:0]); wr(3'd3, {11'h0, FV0[20:16]});
    wr(3'd4, FV1[15:0]); wr(3'd5, {11'h0, FV1[20:16]});
    wr(3'd6, TB[15:0]);  wr(3'd7, {11'h0, TB[20:16]});
    rd_chk("R2 tbase lo", 3'd6, TB[15:0]);
  endtask

  task automatic t_normal();
    clear_irqs(); put(5, 1); put(9, 2);
    expect_win("R5 level", 1, 0, 7'd9, TB + 21'd18);
    clear_irqs(); put(7, 2); put(3, 2);
    expect_win("R5 tie R6", 1, 0, 7'd3, TB + 21'd6);
    clear_irqs(); put(20, 0); irq_pend[41] = 1'b1;
    expect_win("R3 level0", 0, 0, 7'd0, 21'd0);
    clear_irqs(); put(63, 3);
    expect_win("R6 top index", 1, 0, 7'd63, TB + 21'd126);
  endtask

  task automatic t_fast();
    clear_irqs(); put(2, 2); put(40, 2);
    expect_win("R7 R9 fast0", 1, 1, 7'd40, FV0);
    clear_irqs(); put(41, 2); put(40, 2);
    expect_win("R8 both", 1, 1, 7'd40, FV0);
    clear_irqs(); put(41, 2); put(2, 2); put(0, 1);
    expect_win("R9 fast1", 1, 1, 7'd41, FV1);
    clear_irqs(); put(41, 2); put(6, 3);
    expect_win("R7 level3", 1, 0, 7'd6, TB + 21'd12);
    wr(3'd1, 16'd40);
    clear_irqs(); put(40, 2);
    expect_win("R8 same match", 1, 1, 7'd40, FV0);
    wr(3'd1, 16'd41);
  endtask

  task automatic t_same_cycle();
    clear_irqs(); put(12, 2);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = 3'd0; reg_wdata = 16'd12;
    expect_win("R4 old match", 1, 0, 7'd12, TB + 21'd24);
    @(negedge clk); reg_wr = 1'b0;
    expect_win("R4 new match", 1, 1, 7'd12, FV0);
    wr(3'd0, 16'd40);
    clear_irqs();
  endtask

  initial begin
    t_reset();
    t_regs();
    t_normal();
    t_fast();
    t_same_cycle();
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(200000 * 8);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual running expected done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule